// File: doc/BRIEF.md
# Selectable Rotor Substitution Engine

This block performs the character substitution of one stage in a rotor-cipher emulator. Two symbol paths cross it at the same time. The forward path carries symbols travelling away from the keyboard and the return path carries symbols coming back. Each path applies its own permutation of the 64 six-bit symbol values. The permutation is picked from 21 tables held in an external non-volatile store.

Each path has a 6-bit selector word. The low five bits name a table and the top bit chooses the table itself or its inverse, which gives 42 settings per path. Both selectors are captured once, just after reset. The engine then streams the two chosen tables, one bit at a time, into internal registers over a valid/ready handshake. The store may withhold `store_bit_valid` for any number of cycles and the engine simply waits. The engine never withdraws `store_bit_ready` while a table transfer is open.

Once both tables are held, each output is a purely combinational function of its input symbol and the stored table. An inverse lookup compares the input against all 64 entries in parallel. A selector that names a reserved table stops the load and raises an error flag.

Top module: `rotor_subst_engine`

## Requirements
- R1: While `rst_n` is low, `ready`, `config_error` and `store_req` are 0, and both symbol outputs are 0 whatever the symbol inputs are.
- R2: Both selectors are sampled on the first rising clock edge after `rst_n` goes high. Later changes on `fwd_sel` or `ret_sel` have no effect on any output until the next reset.
- R3: The forward table is fetched first, with `store_addr` equal to `fwd_sel[4:0]`. `store_req` then drops for at least one cycle and rises again with `store_addr` equal to `ret_sel[4:0]`. `store_addr` does not change while `store_req` is high.
- R4: A bit is taken on a rising edge where `store_bit_valid` and `store_bit_ready` are both 1. `store_bit_ready` is high only while `store_req` is high. Each table is 384 bits: entry 0 comes first and entry 63 comes last, and each entry arrives most significant bit first. Cycles with `store_bit_valid` low consume nothing.
- R5: `ready` rises on the clock edge that takes the 384th bit of the return table, and then stays high. While `ready` is 0, both symbol outputs are 0.
- R6: When selector bit 5 is 0, the path output equals table[input].
- R7: When selector bit 5 is 1, the path output is the index i such that table[i] equals the input. If no entry matches, the output is 0.
- R8: The two paths are independent. `fwd_sym_out` depends only on `fwd_sym_in` and `fwd_sel`, and `ret_sym_out` depends only on `ret_sym_in` and `ret_sel`. The two selectors may name different tables and directions.
- R9: If either captured selector has an index of 21 to 31, `config_error` goes high on the second edge after reset release and stays high. In that case `store_req` never rises, `ready` stays 0 and both outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwd_sel | input | 6 | Forward path selector: [4:0] table index, [5] inverse |
| ret_sel | input | 6 | Return path selector: [4:0] table index, [5] inverse |
| store_req | output | 1 | High while a table transfer is open |
| store_addr | output | 5 | Index of the table being transferred |
| store_bit_valid | input | 1 | Store presents a table bit |
| store_bit | input | 1 | Table bit value |
| store_bit_ready | output | 1 | Engine accepts a table bit this cycle |
| fwd_sym_in | input | 6 | Forward path input symbol |
| fwd_sym_out | output | 6 | Forward path substituted symbol |
| ret_sym_in | input | 6 | Return path input symbol |
| ret_sym_out | output | 6 | Return path substituted symbol |
| ready | output | 1 | Both tables loaded; outputs are valid |
| config_error | output | 1 | A selector named a reserved table |

## Verification
The assertions assume two things about the store. First, it keeps the table address it was asked for. Second, it delivers tables that are permutations, so an inverse lookup always has exactly one matching entry. They also assume that the selectors are steady across the first edge after reset release.

The bench store model builds every table with an odd multiplier modulo 64, so each table is a permutation. It raises `store_bit_valid` only while `store_req` is high and serves the table named by `store_addr`. It sets the selectors before reset is released and changes them only once capture has happened. One run holds back valid on every fourth cycle, so that stalled transfers are also exercised.

// File: rtl/rse_pkg.sv
package rse_pkg;
  // Selector word format: index in the low bits, inverse flag on top.
  localparam int unsigned IDX_W     = 5;
  localparam int unsigned SEL_W     = IDX_W + 1;
  localparam int unsigned NUM_PATHS = 2;
  localparam int unsigned PATH_FWD  = 0;
  localparam int unsigned PATH_RET  = 1;

  typedef struct packed {
    logic             inverse;
    logic [IDX_W-1:0] idx;
  } map_sel_t;

  typedef enum logic [2:0] {
    LD_WAIT,
    LD_FWD,
    LD_GAP,
    LD_RET,
    LD_DONE,
    LD_FAULT
  } load_state_e;
endpackage

// File: rtl/rse_sel_capture.sv
module rse_sel_capture
  import rse_pkg::*;
#(
  parameter int unsigned NUM_MAPS = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] fwd_sel_in,
  input  logic [SEL_W-1:0] ret_sel_in,
  output map_sel_t         fwd_sel,
  output map_sel_t         ret_sel,
  output logic             captured,
  output logic             sel_bad
);
  // One-shot capture on the first edge after reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_sel  <= '0;
      ret_sel  <= '0;
      captured <= 1'b0;
    end else if (!captured) begin
      fwd_sel  <= map_sel_t'(fwd_sel_in);
      ret_sel  <= map_sel_t'(ret_sel_in);
      captured <= 1'b1;
    end
  end

  // Reserved indices are those at or above the number of stored maps.
  always_comb begin
    sel_bad = (32'(fwd_sel.idx) >= NUM_MAPS) || (32'(ret_sel.idx) >= NUM_MAPS);
  end

  // R2: once captured, the selector registers never move again.
  p_sel_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    captured && $past(captured) |-> $stable(fwd_sel) && $stable(ret_sel));

  p_captured_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> captured);
endmodule

// File: rtl/rse_map_loader.sv
module rse_map_loader
  import rse_pkg::*;
#(
  parameter int unsigned SYM_W = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic                                  sel_bad,
  input  logic [IDX_W-1:0]                      fwd_idx,
  input  logic [IDX_W-1:0]                      ret_idx,
  output logic                                  store_req,
  output logic [IDX_W-1:0]                      store_addr,
  input  logic                                  store_bit_valid,
  input  logic                                  store_bit,
  output logic                                  store_bit_ready,
  output logic [NUM_PATHS-1:0][(SYM_W*(2**SYM_W))-1:0] tables,
  output logic                                  tables_ready,
  output logic                                  config_error
);
  localparam int unsigned ENTRIES    = 2 ** SYM_W;
  localparam int unsigned TABLE_BITS = ENTRIES * SYM_W;
  localparam int unsigned CNT_W      = $clog2(TABLE_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(TABLE_BITS - 1);

  load_state_e      state;
  logic [CNT_W-1:0] bit_cnt;
  logic             take;
  logic             path_open;

  always_comb begin
    path_open       = (state == LD_FWD) || (state == LD_RET);
    store_req       = path_open;
    store_bit_ready = path_open;
    take            = store_bit_valid && path_open;
    unique case (state)
      LD_FWD:  store_addr = fwd_idx;
      LD_RET:  store_addr = ret_idx;
      default: store_addr = '0;
    endcase
    tables_ready = (state == LD_DONE);
    config_error = (state == LD_FAULT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= LD_WAIT;
      bit_cnt <= '0;
      tables  <= '0;
    end else begin
      unique case (state)
        LD_WAIT: begin
          if (start) state <= sel_bad ? LD_FAULT : LD_FWD;
        end
        LD_FWD: begin
          if (take) begin
            tables[PATH_FWD] <= {tables[PATH_FWD][TABLE_BITS-2:0], store_bit};
            if (bit_cnt == LAST_BIT) begin
              bit_cnt <= '0;
              state   <= LD_GAP;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        LD_GAP: state <= LD_RET;
        LD_RET: begin
          if (take) begin
            tables[PATH_RET] <= {tables[PATH_RET][TABLE_BITS-2:0], store_bit};
            if (bit_cnt == LAST_BIT) begin
              bit_cnt <= '0;
              state   <= LD_DONE;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        LD_DONE:  state <= LD_DONE;
        LD_FAULT: state <= LD_FAULT;
        default:  state <= LD_FAULT;
      endcase
    end
  end

  // R3: the table address holds for the whole of an open transfer.
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    store_req && $past(store_req) |-> $stable(store_addr));

  // R5: ready is sticky and no transfer is open once it is set.
  p_ready_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tables_ready |=> tables_ready);

  p_no_req_when_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tables_ready |-> !store_req);

  // R9: a fault never opens a transfer and never becomes ready.
  p_fault_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |-> !store_req && !tables_ready);

  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |=> config_error);
endmodule

// File: rtl/rse_lookup.sv
module rse_lookup #(
  parameter int unsigned SYM_W = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              enable,
  input  logic                              inverse,
  input  logic [(SYM_W*(2**SYM_W))-1:0]     table_bits,
  input  logic [SYM_W-1:0]                  sym_in,
  output logic [SYM_W-1:0]                  sym_out
);
  localparam int unsigned ENTRIES    = 2 ** SYM_W;
  localparam int unsigned TABLE_BITS = ENTRIES * SYM_W;

  logic [SYM_W-1:0]   entry [ENTRIES];
  logic [ENTRIES-1:0] hit;
  logic [SYM_W-1:0]   fwd_val;
  logic [SYM_W-1:0]   inv_val;

  // Entry 0 was shifted in first, so it sits at the top of the vector.
  for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
    assign entry[k] = table_bits[TABLE_BITS-1-k*SYM_W -: SYM_W];
    assign hit[k]   = (entry[k] == sym_in);
  end

  always_comb begin
    fwd_val = entry[sym_in];
    inv_val = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (hit[k]) inv_val = SYM_W'(k);
    end
    sym_out = enable ? (inverse ? inv_val : fwd_val) : '0;
  end

  // R7: an inverse result points back at the presented symbol.
  p_inverse_consistent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enable && inverse && (|hit) |-> entry[sym_out] == sym_in);
endmodule

// File: rtl/rotor_subst_engine.sv
module rotor_subst_engine
  import rse_pkg::*;
#(
  parameter int unsigned SYM_W    = 6,
  parameter int unsigned NUM_MAPS = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       fwd_sel,
  input  logic [5:0]       ret_sel,
  output logic             store_req,
  output logic [4:0]       store_addr,
  input  logic             store_bit_valid,
  input  logic             store_bit,
  output logic             store_bit_ready,
  input  logic [SYM_W-1:0] fwd_sym_in,
  output logic [SYM_W-1:0] fwd_sym_out,
  input  logic [SYM_W-1:0] ret_sym_in,
  output logic [SYM_W-1:0] ret_sym_out,
  output logic             ready,
  output logic             config_error
);
  localparam int unsigned TABLE_BITS = SYM_W * (2 ** SYM_W);

  map_sel_t sel_fwd_q, sel_ret_q;
  logic     captured, sel_bad, tables_ready;
  logic [NUM_PATHS-1:0][TABLE_BITS-1:0] tables;
  logic [NUM_PATHS-1:0][SYM_W-1:0]      sym_in_a, sym_out_a;
  logic [NUM_PATHS-1:0]                 inv_a;

  rse_sel_capture #(.NUM_MAPS(NUM_MAPS)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .fwd_sel_in (fwd_sel),
    .ret_sel_in (ret_sel),
    .fwd_sel    (sel_fwd_q),
    .ret_sel    (sel_ret_q),
    .captured   (captured),
    .sel_bad    (sel_bad)
  );

  rse_map_loader #(.SYM_W(SYM_W)) u_loader (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (captured),
    .sel_bad         (sel_bad),
    .fwd_idx         (sel_fwd_q.idx),
    .ret_idx         (sel_ret_q.idx),
    .store_req       (store_req),
    .store_addr      (store_addr),
    .store_bit_valid (store_bit_valid),
    .store_bit       (store_bit),
    .store_bit_ready (store_bit_ready),
    .tables          (tables),
    .tables_ready    (tables_ready),
    .config_error    (config_error)
  );

  assign sym_in_a[PATH_FWD] = fwd_sym_in;
  assign sym_in_a[PATH_RET] = ret_sym_in;
  assign inv_a[PATH_FWD]    = sel_fwd_q.inverse;
  assign inv_a[PATH_RET]    = sel_ret_q.inverse;

  // One lookup per path, R8: each sees only its own table and selector.
  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    rse_lookup #(.SYM_W(SYM_W)) u_lookup (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (tables_ready),
      .inverse    (inv_a[p]),
      .table_bits (tables[p]),
      .sym_in     (sym_in_a[p]),
      .sym_out    (sym_out_a[p])
    );
  end

  assign fwd_sym_out = sym_out_a[PATH_FWD];
  assign ret_sym_out = sym_out_a[PATH_RET];
  assign ready       = tables_ready;

  // R4: a bit is only ever offered for acceptance inside an open transfer.
  p_ready_inside_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    store_bit_ready |-> store_req);
endmodule

// File: tb/test_rotor_subst_engine.sv
module test_rotor_subst_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] fwd_sel = '0, ret_sel = '0;
  logic       store_req, store_bit_ready, ready, config_error;
  logic [4:0] store_addr;
  logic       store_bit_valid = 1'b0, store_bit = 1'b0;
  logic [5:0] fwd_sym_in = '0, ret_sym_in = '0, fwd_sym_out, ret_sym_out;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rotor_subst_engine i_rotor_subst_engine (
    .clk(clk), .rst_n(rst_n), .fwd_sel(fwd_sel), .ret_sel(ret_sel),
    .store_req(store_req), .store_addr(store_addr),
    .store_bit_valid(store_bit_valid), .store_bit(store_bit),
    .store_bit_ready(store_bit_ready),
    .fwd_sym_in(fwd_sym_in), .fwd_sym_out(fwd_sym_out),
    .ret_sym_in(ret_sym_in), .ret_sym_out(ret_sym_out),
    .ready(ready), .config_error(config_error)
  );

  // Table m: entry e -> ((2m+1)*e + 7m+3) mod 64, a permutation.
  function automatic int map_val(int m, int e);
    return ((2 * m + 1) * e + 7 * m + 3) % 64;
  endfunction

  function automatic int map_inv(int m, int v);
    for (int i = 0; i < 64; i++) if (map_val(m, i) == v) return i;
    return 0;
  endfunction

  function automatic int model(logic [5:0] sel, int x);
    return sel[5] ? map_inv(int'(sel[4:0]), x) : map_val(int'(sel[4:0]), x);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Store model: serves the addressed table, MSB first, entry 0 first.
  int   bit_idx = 0, phase = 0, n_reqs = 0;
  int   req_addr [4];
  bit   rdy_seen = 0, req_prev = 0, stall_mode = 0;
  int   ready_at_last = -1, ready_at_first = -1;

  always @(negedge clk) begin
    if (store_bit_valid && rdy_seen) begin
      bit_idx++;
      if (bit_idx == 384) begin
        if (n_reqs == 1) ready_at_first = int'(ready);
        if (n_reqs == 2) ready_at_last  = int'(ready);
      end
    end
    if (!store_req) bit_idx = 0;
    if (store_req && !req_prev) begin
      if (n_reqs < 4) req_addr[n_reqs] = int'(store_addr);
      n_reqs++;
    end
    req_prev = store_req;
    phase++;
    if (store_req && bit_idx < 384 && !(stall_mode && (phase % 4 == 0))) begin
      int v;
      v = map_val(int'(store_addr), bit_idx / 6);
      store_bit_valid = 1'b1;
      store_bit       = v[5 - (bit_idx % 6)];
    end else begin
      store_bit_valid = 1'b0;
      store_bit       = 1'b0;
    end
    rdy_seen = store_bit_ready;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic start_reset(logic [5:0] fs, logic [5:0] rs);
    @(negedge clk);
    rst_n = 1'b0;
    fwd_sel = fs; ret_sel = rs;
    repeat (3) @(negedge clk);
    n_reqs = 0; ready_at_last = -1; ready_at_first = -1;
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (ready || config_error) break;
    end
    #1;
  endtask

  task automatic sweep(string req, logic [5:0] fs, logic [5:0] rs);
    int bad = 0, fa = 0, fe = 0;
    for (int x = 0; x < 64; x++) begin
      fwd_sym_in = 6'(x); ret_sym_in = 6'(63 - x);
      #1;
      if (int'(fwd_sym_out) != model(fs, x) && bad == 0) begin
        fa = int'(fwd_sym_out); fe = model(fs, x); bad = 1;
      end
      if (int'(ret_sym_out) != model(rs, 63 - x) && bad == 0) begin
        fa = int'(ret_sym_out); fe = model(rs, 63 - x); bad = 1;
      end
    end
    if (bad) check(req, fa, fe); else check(req, 0, 0);
  endtask

  // {input, expected forward (table 3), expected return (table 3 inverse)}
  localparam logic [17:0] VECS [4] = '{
    {6'd0,  6'd24, 6'd24},
    {6'd1,  6'd31, 6'd15},
    {6'd10, 6'd30, 6'd62},
    {6'd63, 6'd17, 6'd33}
  };

  initial begin
    // R1: reset state with symbols applied.
    fwd_sym_in = 6'd9; ret_sym_in = 6'd40;
    repeat (2) @(negedge clk);
    #1;
    check("R1 ready", int'(ready), 0);
    check("R1 config_error", int'(config_error), 0);
    check("R1 store_req", int'(store_req), 0);
    check("R1 outputs", int'(fwd_sym_out) + int'(ret_sym_out), 0);

    // Matched pair: table 3 forward, table 3 inverse.
    start_reset(6'd3, 6'b100011);
    @(negedge clk);                       // capture edge has passed
    fwd_sel = 6'd21; ret_sel = 6'd30;     // R2: must be ignored
    repeat (20) @(negedge clk);
    #1;
    check("R5 outputs zero while loading", int'(fwd_sym_out) + int'(ret_sym_out), 0);
    check("R5 not ready while loading", int'(ready), 0);
    wait_done();
    check("R2 late reserved selector ignored", int'(config_error), 0);
    check("R5 ready", int'(ready), 1);
    check("R5 ready rises with last bit", ready_at_last, 1);
    check("R5 not ready after first table", ready_at_first, 0);
    check("R3 request count", n_reqs, 2);
    check("R3 first address", req_addr[0], 3);
    check("R3 second address", req_addr[1], 3);
    for (int v = 0; v < 4; v++) begin
      fwd_sym_in = VECS[v][17:12]; ret_sym_in = VECS[v][17:12];
      #1;
      check("R6 vector forward", int'(fwd_sym_out), int'(VECS[v][11:6]));
      check("R7 vector inverse", int'(ret_sym_out), int'(VECS[v][5:0]));
    end
    sweep("R6 R7 sweep table 3", 6'd3, 6'b100011);
    fwd_sym_in = 6'd44; #1;
    ret_sym_in = fwd_sym_out; #1;
    check("R7 round trip", int'(ret_sym_out), 44);

    // R8, R4: unmatched paths, store stalls every fourth cycle.
    stall_mode = 1;
    start_reset(6'b110100, 6'd0);
    wait_done();
    check("R4 load with stalls ready", int'(ready), 1);
    check("R3 forward first", req_addr[0], 20);
    check("R3 return second", req_addr[1], 0);
    sweep("R8 independent paths", 6'b110100, 6'd0);
    fwd_sel = 6'd5; ret_sel = 6'b100111;
    repeat (3) @(negedge clk);
    sweep("R2 selector change after load", 6'b110100, 6'd0);
    stall_mode = 0;

    // Boundary tables: 0 inverse forward, 20 forward on return.
    start_reset(6'b100000, 6'd20);
    wait_done();
    sweep("R6 R7 boundary tables", 6'b100000, 6'd20);

    // R9: reserved index on the forward selector.
    start_reset(6'd21, 6'd0);
    @(negedge clk); #1;
    check("R9 no error before decision", int'(config_error), 0);
    @(negedge clk); #1;
    check("R9 error on second edge", int'(config_error), 1);
    fwd_sym_in = 6'd7; ret_sym_in = 6'd7;
    repeat (50) @(negedge clk);
    #1;
    check("R9 no request", n_reqs, 0);
    check("R9 not ready", int'(ready), 0);
    check("R9 outputs zero", int'(fwd_sym_out) + int'(ret_sym_out), 0);

    // R9: reserved index on the return selector with inverse flag.
    start_reset(6'd2, 6'b111111);
    repeat (30) @(negedge clk);
    #1;
    check("R9 return reserved error", int'(config_error), 1);
    check("R9 return reserved no request", n_reqs, 0);

    // R1 again after a completed load.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset clears ready", int'(ready) + int'(config_error), 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule